// File: doc/BRIEF.md
# UART auto-baud rate detector

This block sits beside a UART receiver and works out the host's bit rate from a single synchronization character, ASCII '?' (0x3F), sent with 8 data bits, no parity and one stop bit. Bits go out least significant first. On an idle-high line the character therefore shows three runs: one bit low (start), six bits high (data ones), then two bits low (data zeros), before the stop bit returns the line high. The receive input passes through a two-flop synchronizer. The block counts the length of each run in local clock cycles.

The length of the start-bit run is the bit period. It becomes the divisor for the baud rate generator. The high run and the second low run are cross-checked against that period. A character that does not fit the pattern raises an error flag instead of a divisor. So does a line that stops toggling partway through. The result is held until software re-arms the detector by taking `arm` low and then high again. After a re-arm the block waits for a fresh falling edge. The local clock only needs to be fast enough that a bit lasts at least `MIN_DIV` cycles.

Top module: `autobaud_sync`

## Requirements
- R1: After reset, `divisor` is 0, `lock` is 0 and `err` is 0.
- R2: `rxd` is sampled by two flops before edge detection. `lock` is high in the cycle that follows the third rising clock edge after `rxd` rises at the end of the second low run.
- R3: For an accepted character, `divisor` takes the number of clock cycles the start-bit run stayed low, and `lock` is high for exactly one cycle.
- R4: With L1 the start-bit run length and H the high run length, the character is accepted only if 9·L1 ≤ 2·H ≤ 15·L1 (six bit periods ±25%). Otherwise `err` is set and no lock occurs.
- R5: With L2 the second low run length, the character is accepted only if 3·L1 ≤ 2·L2 ≤ 5·L1 (two bit periods ±25%). Otherwise `err` is set.
- R6: A start-bit run shorter than `MIN_DIV` cycles sets `err`.
- R7: Once the first falling edge has been seen, a run whose saturating counter reaches 2^CNT_W−1 without the expected edge sets `err`.
- R8: `divisor` and `err` hold their values until a re-arm. When `arm` is seen high after having been low, `divisor` and `err` are cleared and the block waits for a new falling edge.
- R9: While `arm` is low, line activity causes no lock and no error, and `divisor` keeps its value.
- R10: After a lock or an error, further characters are ignored until the next re-arm.
- R11: `lock` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Enable; a low-to-high change re-arms the detector |
| rxd | input | 1 | Raw serial receive line, idle high |
| divisor | output | CNT_W | Measured bit period in clock cycles |
| lock | output | 1 | One-cycle pulse when a divisor has been accepted |
| err | output | 1 | Malformed pattern or timeout; held until re-arm |

## Verification
A miscounted run shows up in one of two ways. Either the divisor is off from the driven bit period, or an in-tolerance character is rejected within a few cycles of the edge that closes the bad run. A misplaced tolerance bound shows only at the exact run lengths on either side of each limit, so those lengths are driven one cycle apart. A state that fails to clear or hold shows as a stale divisor, a stale error or an extra lock pulse right after the next re-arm or the next character.

// File: rtl/autobaud_sync.sv
module autobaud_sync #(
  parameter int CNT_W   = 20,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             rxd,
  output logic [CNT_W-1:0] divisor,
  output logic             lock,
  output logic             err
);
  localparam int CW = CNT_W + 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_DIV);

  typedef enum logic [2:0] {S_OFF, S_WAIT, S_LOW1, S_HIGH, S_LOW2, S_HOLD} st_t;
  st_t st;

  logic rx_s1, rx_s2, rx_d;
  logic [CNT_W-1:0] cnt, run1;

  wire fall = rx_d & ~rx_s2;
  wire rise = ~rx_d & rx_s2;

  wire [CW-1:0] l1w = CW'(run1);
  wire [CW-1:0] cw  = CW'(cnt);
  wire [CW-1:0] c2  = cw << 1;
  wire h_ok  = (c2 >= (l1w << 3) + l1w) && (c2 <= (l1w << 4) - l1w);
  wire l2_ok = (c2 >= (l1w << 1) + l1w) && (c2 <= (l1w << 2) + l1w);
  wire tmo   = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_d    <= 1'b1;
      st      <= S_OFF;
      cnt     <= '0;
      run1    <= '0;
      divisor <= '0;
      lock    <= 1'b0;
      err     <= 1'b0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      rx_d  <= rx_s2;
      lock  <= 1'b0;
      if (!tmo) cnt <= cnt + 1'b1;
      case (st)
        S_OFF: if (arm) begin
          divisor <= '0;
          err     <= 1'b0;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          if (!arm) st <= S_OFF;
          else if (fall) begin
            cnt <= CNT_W'(1);
            st  <= S_LOW1;
          end
        end
        S_LOW1: begin
          if (!arm) st <= S_OFF;
          else if (rise) begin
            if (cnt < CNT_MIN) begin
              err <= 1'b1;
              st  <= S_HOLD;
            end else begin
              run1 <= cnt;
              cnt  <= CNT_W'(1);
              st   <= S_HIGH;
            end
          end else if (tmo) begin
            err <= 1'b1;
            st  <= S_HOLD;
          end
        end
        S_HIGH: begin
          if (!arm) st <= S_OFF;
          else if (fall) begin
            if (h_ok) begin
              cnt <= CNT_W'(1);
              st  <= S_LOW2;
            end else begin
              err <= 1'b1;
              st  <= S_HOLD;
            end
          end else if (tmo) begin
            err <= 1'b1;
            st  <= S_HOLD;
          end
        end
        S_LOW2: begin
          if (!arm) st <= S_OFF;
          else if (rise) begin
            if (l2_ok) begin
              divisor <= run1;
              lock    <= 1'b1;
            end else begin
              err <= 1'b1;
            end
            st <= S_HOLD;
          end else if (tmo) begin
            err <= 1'b1;
            st  <= S_HOLD;
          end
        end
        S_HOLD: if (!arm) st <= S_OFF;
        default: st <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/autobaud_sync_chk.sv
module autobaud_sync_chk #(
  parameter int CNT_W   = 20,
  parameter int MIN_DIV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic [CNT_W-1:0] divisor,
  input logic             lock,
  input logic             err
);
  // R3: lock is a single-cycle pulse
  p_lock_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> !lock);

  // R11: lock and error are exclusive
  p_lock_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock && err));

  // R6: an accepted divisor is never below the minimum
  p_div_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (divisor >= CNT_W'(MIN_DIV)));

  // R8: divisor only moves on a lock or on the clear of a re-arm
  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != $past(divisor)) |-> (lock || divisor == '0));

  // R8: error clears only right after arm is seen rising
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> ($past(arm) && !$past(arm, 2)));

  // R10: no lock while an error is held
  p_no_lock_after_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !lock);
endmodule

bind autobaud_sync autobaud_sync_chk #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .arm(arm), .divisor(divisor), .lock(lock), .err(err)
);

// File: tb/autobaud_sync_tb_top.sv
`timescale 1ns/1ps
module autobaud_sync_tb_top;
  localparam int CNT_W = 12;
  localparam int MIN_DIV = 4;
  localparam int NV = 13;
  // l1, h, l2, expect lock
  localparam int VEC [NV][4] = '{
    '{8, 48, 16, 1},    // R3 nominal
    '{16, 96, 32, 1},   // R3
    '{87, 522, 174, 1}, // R3 slow line
    '{4, 24, 8, 1},     // R6 minimum period accepted
    '{3, 18, 6, 0},     // R6 below minimum
    '{8, 60, 20, 1},    // R4 R5 upper bounds
    '{8, 36, 12, 1},    // R4 R5 lower bounds
    '{8, 61, 16, 0},    // R4 high too long
    '{8, 35, 16, 0},    // R4 high too short
    '{8, 48, 21, 0},    // R5 low too long
    '{8, 48, 11, 0},    // R5 low too short
    '{8, 56, 8, 0},     // R5 seven ones then one zero
    '{8, 32, 16, 0}     // R4 four ones
  };

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, rxd = 1'b1;
  logic [CNT_W-1:0] divisor;
  logic lock, err;
  int checks = 0, errors = 0, cyc = 0, lock_cnt = 0, lock_cyc = 0, rise_cyc = 0;
  bit done = 0;

  autobaud_sync #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rxd(rxd),
    .divisor(divisor), .lock(lock), .err(err));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (lock) begin lock_cnt++; lock_cyc = cyc; end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rearm();
    arm = 1'b0;
    repeat (2) @(negedge clk);
    arm = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(int l1, int h, int l2);
    rxd = 1'b0; repeat (l1) @(negedge clk);
    rxd = 1'b1; repeat (h) @(negedge clk);
    rxd = 1'b0; repeat (l2) @(negedge clk);
    rxd = 1'b1; rise_cyc = cyc;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 divisor", int'(divisor), 0);
    chk("R1 lock", int'(lock), 0);
    chk("R1 err", int'(err), 0);

    for (int i = 0; i < NV; i++) begin
      rearm();
      base = lock_cnt;
      send(VEC[i][0], VEC[i][1], VEC[i][2]);
      chk($sformatf("R3 R4 R5 R6 lock count v%0d", i), lock_cnt - base, VEC[i][3]);
      chk($sformatf("R4 R5 R6 err v%0d", i), int'(err), 1 - VEC[i][3]);
      chk($sformatf("R3 divisor v%0d", i), int'(divisor), VEC[i][3] ? VEC[i][0] : 0);
      if (VEC[i][3] != 0) chk($sformatf("R2 latency v%0d", i), lock_cyc - rise_cyc, 3);
    end

    // R10 and R9: hold after lock, ignore when disarmed
    rearm();
    send(8, 48, 16);
    chk("R3 divisor before hold", int'(divisor), 8);
    base = lock_cnt;
    send(16, 96, 32);
    chk("R10 no relock", lock_cnt - base, 0);
    chk("R10 divisor held", int'(divisor), 8);
    arm = 1'b0;
    repeat (2) @(negedge clk);
    send(16, 96, 32);
    chk("R9 no lock disarmed", lock_cnt - base, 0);
    chk("R9 no err disarmed", int'(err), 0);
    chk("R9 R8 divisor held", int'(divisor), 8);
    arm = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 divisor cleared", int'(divisor), 0);
    send(16, 96, 32);
    chk("R8 fresh lock", int'(divisor), 16);

    // R10 and R8: error held until re-arm
    rearm();
    send(8, 61, 16);
    chk("R4 err set", int'(err), 1);
    base = lock_cnt;
    send(8, 48, 16);
    chk("R10 no lock while err", lock_cnt - base, 0);
    chk("R8 err held", int'(err), 1);
    rearm();
    chk("R8 err cleared", int'(err), 0);

    // R7: timeout in the high run
    rxd = 1'b0; repeat (8) @(negedge clk);
    rxd = 1'b1; repeat (3000) @(negedge clk);
    chk("R7 no early timeout", int'(err), 0);
    repeat (1200) @(negedge clk);
    chk("R7 timeout err", int'(err), 1);
    chk("R7 no divisor", int'(divisor), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule